// File: doc/BRIEF.md
# Ghost Key and Fn-Layer Filter

This block takes one snapshot of decoded key positions from a keyboard matrix scanner and turns it into a filtered list of scancodes. Each input entry is a byte with a valid flag, a row number and a column number. Entries without the valid flag are dropped. The entries that remain are packed, in input order, into a list of kept scancodes.

Two options shape the result. With the function layer enabled, an entry whose scancode equals a programmed function-key code is consumed instead of kept. Its presence moves every kept scancode into the upper half of the keymap, which means adding 128. With ghost filtering enabled and at least three kept keys, the block walks every pair of kept keys, one pair per clock. It raises a discard flag when some pair shares a row and some pair, possibly a different one, shares a column. Downstream logic should ignore a discarded snapshot. A start strobe launches each snapshot and a one-cycle done strobe marks the finished result.

Top module: `keyset_ghost_filter`

## Requirements
- R1: Entry k occupies bits [8k+7:8k] of `entries_i`. Bit 7 is the valid flag, bits 6:3 hold the row and bits 2:0 the column. A scancode is row*8+column, and kept scancode k is presented on `codes_o[8k+7:8k]`.
- R2: Entries whose valid bit is clear are skipped. Kept scancodes fill slots 0 upward in input order, and every slot at or above `kept_cnt_o` reads zero.
- R3: When `fn_layer_en_i` is 1, a valid entry whose 7-bit scancode equals `fn_code_i` is not kept and not counted, and it marks the function key as held.
- R4: When the function key is held, bit 7 of every kept scancode is set (value plus 128). When `fn_layer_en_i` is 0, an entry matching `fn_code_i` is kept like any other key and no scancode is shifted.
- R5: The pair check runs only when `ghost_en_i` is 1 and at least 3 keys are kept. Otherwise, with start sampled at clock edge 0, `done_o` is high in the cycle after edge 0 and `discard_o` is 0.
- R6: `discard_o` is 1 exactly when, among the kept keys before any shift, at least one pair shares a row and at least one pair shares a column. The two pairs need not be the same.
- R7: The check compares one pair per clock. With n kept keys and P = n(n-1)/2 pairs, `done_o` is high in the cycle after clock edge P, counting the start edge as edge 0.
- R8: `done_o` is high for exactly one cycle. `kept_cnt_o`, `codes_o` and `discard_o` hold their values until the next accepted start.
- R9: A start strobe that arrives while a pair check is running is ignored and does not change the result of the snapshot in progress.
- R10: After reset, `done_o`, `kept_cnt_o`, `codes_o` and `discard_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept the snapshot on `entries_i` |
| entries_i | input | 64 | Eight entry bytes (valid, row, column) |
| fn_code_i | input | 7 | Scancode of the function key |
| fn_layer_en_i | input | 1 | Enable consumption of the function key and the upper-layer remap |
| ghost_en_i | input | 1 | Enable the row/column pair check |
| done_o | output | 1 | One-cycle strobe when the result is ready |
| kept_cnt_o | output | 4 | Number of kept scancodes |
| codes_o | output | 64 | Kept scancodes, slot 0 in the low byte |
| discard_o | output | 1 | Snapshot judged ghosted |

## Verification
The bench builds the block with its default parameters: eight entries, a 4-bit row and a 3-bit column. At these values a full snapshot needs the longest walk of 28 pairs, and the function-layer shift lands on bit 7 of each byte. The directed cases cover a row match and a column match that come from different pairs. They also cover a consumed function key that drops the kept count below three, which skips the walk. A start pulse placed in the middle of a 28-pair walk tests that busy starts are rejected.

// File: rtl/kgf_pkg.sv
package kgf_pkg;

   typedef enum logic {
      KGF_IDLE = 1'b0,
      KGF_WALK = 1'b1
   } kgf_state_e;

   function automatic int kgf_pairs(input int n);
      return (n * (n - 1)) / 2;
   endfunction

endpackage

// File: rtl/kgf_compact.sv
module kgf_compact #(
   parameter int N_ENT = 8,
   parameter int ROW_W = 4,
   parameter int COL_W = 3,
   parameter int RAW_W = ROW_W + COL_W,
   parameter int CNT_W = $clog2(N_ENT + 1),
   parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic [N_ENT*(RAW_W+1)-1:0] entries,
   input  logic [RAW_W-1:0]           fn_code,
   input  logic                       fn_layer_en,
   output logic [RAW_W-1:0]           list [N_ENT],
   output logic [CNT_W-1:0]           n_kept,
   output logic                       fn_seen
);
   localparam int ENT_W = RAW_W + 1;

   always_comb begin
      logic [CNT_W-1:0] n;
      logic [ENT_W-1:0] ent;
      n       = '0;
      fn_seen = 1'b0;
      for (int k = 0; k < N_ENT; k++) list[k] = '0;
      for (int k = 0; k < N_ENT; k++) begin
         ent = entries[k*ENT_W +: ENT_W];
         if (ent[ENT_W-1]) begin
            if (fn_layer_en && (ent[RAW_W-1:0] == fn_code)) begin
               fn_seen = 1'b1;
            end else begin
               list[n[IDX_W-1:0]] = ent[RAW_W-1:0];
               n = n + 1'b1;
            end
         end
      end
      n_kept = n;
   end

endmodule

// File: rtl/kgf_pair_seq.sv
module kgf_pair_seq #(
   parameter int N_ENT = 8,
   parameter int CNT_W = $clog2(N_ENT + 1),
   parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt,
   output logic [IDX_W-1:0] idx_a,
   output logic [IDX_W-1:0] idx_b,
   output logic             last
);
   logic b_at_end;

   assign b_at_end = (CNT_W'(idx_b) + 1'b1) == cnt;
   assign last     = b_at_end && ((CNT_W'(idx_a) + CNT_W'(2)) == cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_a <= '0;
         idx_b <= IDX_W'(1);
      end else if (load) begin
         idx_a <= '0;
         idx_b <= IDX_W'(1);
      end else if (step && !last) begin
         if (b_at_end) begin
            idx_a <= idx_a + 1'b1;
            idx_b <= idx_a + IDX_W'(2);
         end else begin
            idx_b <= idx_b + 1'b1;
         end
      end
   end

endmodule

// File: rtl/keyset_ghost_filter.sv
module keyset_ghost_filter #(
   parameter int N_ENT = 8,
   parameter int ROW_W = 4,
   parameter int COL_W = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start_i,
   input  logic [N_ENT*(ROW_W+COL_W+1)-1:0]   entries_i,
   input  logic [ROW_W+COL_W-1:0]             fn_code_i,
   input  logic                               fn_layer_en_i,
   input  logic                               ghost_en_i,
   output logic                               done_o,
   output logic [$clog2(N_ENT+1)-1:0]         kept_cnt_o,
   output logic [N_ENT*(ROW_W+COL_W+1)-1:0]   codes_o,
   output logic                               discard_o
);
   import kgf_pkg::*;

   localparam int RAW_W  = ROW_W + COL_W;
   localparam int CODE_W = RAW_W + 1;
   localparam int CNT_W  = $clog2(N_ENT + 1);
   localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
   localparam int MIN_GHOST = 3;

   if (N_ENT < 2) begin : g_bad_depth
      $error("keyset_ghost_filter: N_ENT must be at least 2");
   end
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("keyset_ghost_filter: row and column widths must be positive");
   end

   logic [RAW_W-1:0] cand   [N_ENT];
   logic [CNT_W-1:0] cand_n;
   logic             cand_fn;

   kgf_compact #(
      .N_ENT(N_ENT), .ROW_W(ROW_W), .COL_W(COL_W),
      .RAW_W(RAW_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_compact (
      .entries    (entries_i),
      .fn_code    (fn_code_i),
      .fn_layer_en(fn_layer_en_i),
      .list       (cand),
      .n_kept     (cand_n),
      .fn_seen    (cand_fn)
   );

   kgf_state_e       state_q;
   logic [RAW_W-1:0] raw_q [N_ENT];
   logic [CNT_W-1:0] cnt_q;
   logic             fnh_q;
   logic             row_hit_q, col_hit_q;
   logic             done_q, disc_q;

   logic             accept, need_walk, walking;
   logic [IDX_W-1:0] pa, pb;
   logic             pair_last;
   logic             row_eq, col_eq;

   assign accept    = start_i && (state_q == KGF_IDLE);
   assign need_walk = ghost_en_i && (cand_n >= CNT_W'(MIN_GHOST));
   assign walking   = (state_q == KGF_WALK);

   kgf_pair_seq #(
      .N_ENT(N_ENT), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_pairs (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .step (walking),
      .cnt  (cnt_q),
      .idx_a(pa),
      .idx_b(pb),
      .last (pair_last)
   );

   assign row_eq = raw_q[pa][RAW_W-1:COL_W] == raw_q[pb][RAW_W-1:COL_W];
   assign col_eq = raw_q[pa][COL_W-1:0]     == raw_q[pb][COL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= KGF_IDLE;
         cnt_q     <= '0;
         fnh_q     <= 1'b0;
         row_hit_q <= 1'b0;
         col_hit_q <= 1'b0;
         done_q    <= 1'b0;
         disc_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            cnt_q     <= cand_n;
            fnh_q     <= cand_fn;
            row_hit_q <= 1'b0;
            col_hit_q <= 1'b0;
            disc_q    <= 1'b0;
            if (need_walk) begin
               state_q <= KGF_WALK;
            end else begin
               done_q  <= 1'b1;
            end
         end else if (walking) begin
            row_hit_q <= row_hit_q | row_eq;
            col_hit_q <= col_hit_q | col_eq;
            if (pair_last) begin
               done_q  <= 1'b1;
               disc_q  <= (row_hit_q | row_eq) & (col_hit_q | col_eq);
               state_q <= KGF_IDLE;
            end
         end
      end
   end

   for (genvar k = 0; k < N_ENT; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            raw_q[k] <= '0;
         end else if (accept) begin
            raw_q[k] <= cand[k];
         end
      end
      assign codes_o[k*CODE_W +: CODE_W] =
         (CNT_W'(k) < cnt_q) ? {fnh_q, raw_q[k]} : '0;
   end

   assign done_o     = done_q;
   assign kept_cnt_o = cnt_q;
   assign discard_o  = disc_q;

endmodule

// File: rtl/kgf_checker.sv
module kgf_checker #(
   parameter int N_ENT = 8,
   parameter int ROW_W = 4,
   parameter int COL_W = 3
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             start_i,
   input logic                             done_o,
   input logic [$clog2(N_ENT+1)-1:0]       kept_cnt_o,
   input logic [N_ENT*(ROW_W+COL_W+1)-1:0] codes_o,
   input logic                             discard_o
);
   localparam int CW    = ROW_W + COL_W + 1;
   localparam int CNT_W = $clog2(N_ENT + 1);

   function automatic logic tail_clear(input logic [N_ENT*CW-1:0] c,
                                       input logic [CNT_W-1:0] n);
      for (int k = 0; k < N_ENT; k++)
         if (CNT_W'(k) >= n && c[k*CW +: CW] != '0) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic layer_uniform(input logic [N_ENT*CW-1:0] c,
                                          input logic [CNT_W-1:0] n);
      for (int k = 1; k < N_ENT; k++)
         if (CNT_W'(k) < n && c[k*CW + CW - 1] != c[CW - 1]) return 1'b0;
      return 1'b1;
   endfunction

   // R2
   unused_slots_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> tail_clear(codes_o, kept_cnt_o));

   // R2
   count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kept_cnt_o <= CNT_W'(N_ENT));

   // R4
   layer_bit_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> layer_uniform(codes_o, kept_cnt_o));

   // R5
   discard_needs_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && discard_o) |-> kept_cnt_o >= CNT_W'(3));

   // R8
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R8
   result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(kept_cnt_o) && $stable(codes_o)));

   // R8
   discard_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(discard_o) or $fell(discard_o));

endmodule

bind keyset_ghost_filter kgf_checker #(
   .N_ENT(N_ENT), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .done_o    (done_o),
   .kept_cnt_o(kept_cnt_o),
   .codes_o   (codes_o),
   .discard_o (discard_o)
);

// File: tb/sim_keyset_ghost_filter.sv
module sim_keyset_ghost_filter;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] entries_i = '0;
   logic [6:0]  fn_code_i = '0;
   logic        fn_layer_en_i = 1'b0;
   logic        ghost_en_i = 1'b0;
   logic        done_o;
   logic [3:0]  kept_cnt_o;
   logic [63:0] codes_o;
   logic        discard_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyset_ghost_filter u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .entries_i(entries_i),
      .fn_code_i(fn_code_i), .fn_layer_en_i(fn_layer_en_i),
      .ghost_en_i(ghost_en_i), .done_o(done_o), .kept_cnt_o(kept_cnt_o),
      .codes_o(codes_o), .discard_o(discard_o)
   );

   function automatic logic [7:0] mk(input int row, input int col);
      return {1'b1, 4'(row), 3'(col)};
   endfunction

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [63:0] ent, input logic [6:0] fc,
                        input logic fe, input logic ge,
                        output int n, output logic [63:0] codes,
                        output logic disc, output int lat);
      logic [6:0] lst [8];
      logic fh, rm, cm;
      n = 0; fh = 0; rm = 0; cm = 0; codes = '0;
      for (int k = 0; k < N; k++) begin
         logic [7:0] e;
         e = ent[k*8 +: 8];
         if (e[7]) begin
            if (fe && e[6:0] == fc) fh = 1'b1;
            else begin lst[n] = e[6:0]; n++; end
         end
      end
      if (ge && n >= 3)
         for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++) begin
               if (lst[i][2:0] == lst[j][2:0]) cm = 1'b1;
               if (lst[i][6:3] == lst[j][6:3]) rm = 1'b1;
            end
      disc = rm & cm;
      lat  = (ge && n >= 3) ? (n * (n - 1)) / 2 + 1 : 1;
      for (int k = 0; k < n; k++) codes[k*8 +: 8] = {fh, lst[k]};
   endtask

   task automatic drive(input logic [63:0] ent, input logic [6:0] fc,
                        input logic fe, input logic ge);
      entries_i = ent; fn_code_i = fc; fn_layer_en_i = fe; ghost_en_i = ge;
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 1;
      while (!done_o && lat < 100) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic judge(input string req, input int n, input logic [63:0] codes,
                        input logic disc, input int lat, input int got_lat);
      int held_n;
      chk(done_o == 1'b1, req, "done seen", 64'(done_o), 64'd1);
      chk(got_lat == lat, req, "done latency (R7)", 64'(got_lat), 64'(lat));
      chk(kept_cnt_o == 4'(n), req, "kept count", 64'(kept_cnt_o), 64'(n));
      chk(codes_o == codes, req, "codes", codes_o, codes);
      chk(discard_o == disc, req, "discard", 64'(discard_o), 64'(disc));
      held_n = int'(kept_cnt_o);
      @(negedge clk);
      // R8: pulse is one cycle wide and results stay put
      chk(done_o == 1'b0, "R8", "done width", 64'(done_o), 64'd0);
      chk(codes_o == codes && int'(kept_cnt_o) == held_n, "R8", "result held",
          codes_o, codes);
   endtask

   task automatic run_case(input string req, input logic [63:0] ent,
                           input logic [6:0] fc, input logic fe, input logic ge);
      int n, lat, got;
      logic [63:0] codes;
      logic disc;
      model(ent, fc, fe, ge, n, codes, disc, lat);
      drive(ent, fc, fe, ge);
      wait_done(got);
      judge(req, n, codes, disc, lat, got);
   endtask

   task automatic t_reset();
      // R10
      chk(done_o == 0, "R10", "done after reset", 64'(done_o), 0);
      chk(kept_cnt_o == 0, "R10", "count after reset", 64'(kept_cnt_o), 0);
      chk(codes_o == 0, "R10", "codes after reset", codes_o, 0);
      chk(discard_o == 0, "R10", "discard after reset", 64'(discard_o), 0);
   endtask

   task automatic t_basic();
      // R1: two keys, no walk; also the field layout
      run_case("R1", {48'h0, mk(9,1), mk(2,5)}, 7'h00, 1'b0, 1'b1);
      chk(codes_o[7:0] == 8'd21, "R1", "row*8+col", 64'(codes_o[7:0]), 64'd21);
   endtask

   task automatic t_compact();
      logic [63:0] e;
      e = '0;
      e[0*8 +: 8] = 8'h7F;
      e[1*8 +: 8] = mk(3,3);
      e[2*8 +: 8] = 8'h55;
      e[4*8 +: 8] = mk(0,7);
      e[6*8 +: 8] = mk(15,0);
      // R2
      run_case("R2", e, 7'h00, 1'b0, 1'b0);
   endtask

   task automatic t_fn_on();
      // R3 R4: function key consumed, others move up by 128
      run_case("R3", {40'h0, mk(6,1), mk(1,2), mk(4,4)}, 7'h0A, 1'b1, 1'b1);
      chk(codes_o[7:0] == 8'hA4, "R4", "shifted code", 64'(codes_o[7:0]), 64'hA4);
   endtask

   task automatic t_fn_off();
      // R4: layer off, matching key kept and nothing shifted
      run_case("R4", {40'h0, mk(6,1), mk(1,2), mk(4,4)}, 7'h0A, 1'b0, 1'b0);
   endtask

   task automatic t_fn_absent();
      // R4: layer on, key absent, no shift
      run_case("R4", {48'h0, mk(6,1), mk(4,4)}, 7'h0A, 1'b1, 1'b0);
   endtask

   task automatic t_ghost_tri();
      // R6 R7: classic three-key ghost
      run_case("R6", {40'h0, mk(1,0), mk(0,1), mk(0,0)}, 7'h00, 1'b0, 1'b1);
   endtask

   task automatic t_ghost_split();
      // R6: row match and column match from different pairs
      run_case("R6", {32'h0, mk(5,3), mk(2,3), mk(0,1), mk(0,0)}, 7'h00, 1'b0, 1'b1);
   endtask

   task automatic t_clean();
      // R7: three distinct keys, walk of 3 pairs, no discard
      run_case("R7", {40'h0, mk(2,2), mk(1,1), mk(0,0)}, 7'h00, 1'b0, 1'b1);
   endtask

   task automatic t_ghost_off();
      // R5: filtering disabled
      run_case("R5", {40'h0, mk(1,0), mk(0,1), mk(0,0)}, 7'h00, 1'b0, 1'b0);
   endtask

   task automatic t_fn_drop();
      // R5 R3: consumed key leaves two, walk skipped
      run_case("R5", {40'h0, mk(1,0), mk(0,1), mk(0,0)}, 7'h08, 1'b1, 1'b1);
   endtask

   function automatic logic [63:0] full_set();
      logic [63:0] e;
      for (int k = 0; k < N; k++) e[k*8 +: 8] = mk(k, 7 - k);
      return e;
   endfunction

   task automatic t_full();
      // R7: 28 pairs
      run_case("R7", full_set(), 7'h00, 1'b0, 1'b1);
   endtask

   task automatic t_busy();
      int n, lat, got;
      logic [63:0] codes;
      logic disc;
      model(full_set(), 7'h00, 1'b0, 1'b1, n, codes, disc, lat);
      drive(full_set(), 7'h00, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      // R9: start during the walk with a ghosted, smaller snapshot
      entries_i = {40'h0, mk(1,0), mk(0,1), mk(0,0)};
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(got);
      judge("R9", n, codes, disc, lat, got + 5);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_compact();
      t_fn_on();
      t_fn_off();
      t_fn_absent();
      t_ghost_tri();
      t_ghost_split();
      t_clean();
      t_ghost_off();
      t_fn_drop();
      t_full();
      t_busy();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule